// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Element Row

This block is a row of identical one-bit processing elements. Each column has its own single-bit data bus, and all columns obey one 4-bit opcode that is broadcast every cycle. Each element holds three one-bit registers, A, B and C, which feed a full adder. Every operation does one of three things:

- loads a register from the column bus, in true or inverted form;
- drives one tap of the adder logic onto the bus;
- drives the sum while the carry is written back into C.

Multi-bit words are handled least significant bit first.

For a serial add, C is cleared first, and then each bit takes three cycles: load A, load B, then drive the sum with carry feedback. For a serial subtract, C is set first and the subtrahend is loaded into A inverted, so the carry tap acts as a borrow chain. A row-wide OR of every C register gives the sequencer a single flag for "any column still active". Memory and sequencing sit outside this block.

Top module: `pe_row`

## Requirements
- R1: While reset is low and after it is released, A, B and C are 0 in every column. `any_c` is 0, and `bus_out` is 0 for every opcode.
- R2: At the next rising edge, the load opcodes take the column bus value: 3 loads C, 6 loads B, 8 loads B inverted, 10 loads A and 11 loads A inverted.
- R3: Opcode 13 drives the sum A^B^C. Opcode 2 drives the carry, which is the majority of A, B and C. Both are combinational from the current registers.
- R4: The drive opcodes produce these functions: 0 drives B|C, 1 drives B&C, 4 drives (A ? C : B), 5 drives (A ? B : C), 7 drives B and 9 drives B^C.
- R5: Opcode 14 drives the sum of the current A, B and C. At the edge it writes their carry into C and leaves A and B unchanged.
- R6: Opcode 12 loads A from the bus. In the same edge it writes into C the carry of the A, B and C values that held before that edge.
- R7: `drive_en` is 1 exactly for opcodes 0, 1, 2, 4, 5, 7, 9, 13 and 14. For every other opcode, `bus_out` is 0 in all columns.
- R8: Opcode 15 changes no register.
- R9: `any_c` is the OR of the C registers of all columns, taken from the current register state.
- R10: Serial arithmetic works LSB first. With C cleared and per-bit steps (10, 6, 14), the driven sum bits form x+y modulo 2^W. With C set and steps (11 with y, 6 with x, 14), they form x−y modulo 2^W.
- R11: An opcode leaves unchanged every register it does not name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op | input | 4 | Broadcast opcode |
| bus_in | input | N_COLS | Per-column bus value for loads |
| bus_out | output | N_COLS | Per-column value driven by the element |
| drive_en | output | 1 | Opcode drives the bus |
| any_c | output | 1 | OR of all C registers |

## Verification
The hardest situation to reach from the ports is the opcode 12 corner case. There, C must take a carry formed from the old A while A changes in the same edge, and this only shows up when the old and new A differ and B and C are unequal. A long run of random opcodes with random per-column bus values reaches all eight register combinations many times in every column. Directed serial add and subtract words then chain the carry feedback over every bit position.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_DRV_OR    = 4'd0,
    OP_DRV_AND   = 4'd1,
    OP_DRV_CY    = 4'd2,
    OP_LD_C      = 4'd3,
    OP_DRV_SELC  = 4'd4,
    OP_DRV_SELB  = 4'd5,
    OP_LD_B      = 4'd6,
    OP_DRV_B     = 4'd7,
    OP_LD_NB     = 4'd8,
    OP_DRV_XOR   = 4'd9,
    OP_LD_A      = 4'd10,
    OP_LD_NA     = 4'd11,
    OP_LD_A_CF   = 4'd12,
    OP_DRV_SUM   = 4'd13,
    OP_DRV_SUMCF = 4'd14,
    OP_IDLE      = 4'd15
  } pe_op_e;

  typedef enum logic [3:0] {
    TAP_NONE, TAP_OR, TAP_AND, TAP_CARRY, TAP_SELC,
    TAP_SELB, TAP_B, TAP_XOR, TAP_SUM
  } tap_e;

  typedef struct packed {
    logic ld_a;
    logic ld_b;
    logic ld_c;
    logic invert;
    logic carry_fb;
    tap_e tap;
  } pe_ctrl_t;

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic tap_value(input tap_e t, input logic a,
                                     input logic b, input logic c);
    logic r;
    case (t)
      TAP_OR:    r = b | c;
      TAP_AND:   r = b & c;
      TAP_CARRY: r = fa_carry(a, b, c);
      TAP_SELC:  r = a ? c : b;
      TAP_SELB:  r = a ? b : c;
      TAP_B:     r = b;
      TAP_XOR:   r = b ^ c;
      TAP_SUM:   r = fa_sum(a, b, c);
      default:   r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pe_decode.sv
module pe_decode
  import pe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op,
  output pe_ctrl_t        ctrl,
  output logic            drive_en
);
  always_comb begin
    ctrl = '{ld_a: 1'b0, ld_b: 1'b0, ld_c: 1'b0, invert: 1'b0,
             carry_fb: 1'b0, tap: TAP_NONE};
    case (pe_op_e'(op))
      OP_DRV_OR:    ctrl.tap = TAP_OR;
      OP_DRV_AND:   ctrl.tap = TAP_AND;
      OP_DRV_CY:    ctrl.tap = TAP_CARRY;
      OP_LD_C:      ctrl.ld_c = 1'b1;
      OP_DRV_SELC:  ctrl.tap = TAP_SELC;
      OP_DRV_SELB:  ctrl.tap = TAP_SELB;
      OP_LD_B:      ctrl.ld_b = 1'b1;
      OP_DRV_B:     ctrl.tap = TAP_B;
      OP_LD_NB:     begin ctrl.ld_b = 1'b1; ctrl.invert = 1'b1; end
      OP_DRV_XOR:   ctrl.tap = TAP_XOR;
      OP_LD_A:      ctrl.ld_a = 1'b1;
      OP_LD_NA:     begin ctrl.ld_a = 1'b1; ctrl.invert = 1'b1; end
      OP_LD_A_CF:   begin ctrl.ld_a = 1'b1; ctrl.carry_fb = 1'b1; end
      OP_DRV_SUM:   ctrl.tap = TAP_SUM;
      OP_DRV_SUMCF: begin ctrl.tap = TAP_SUM; ctrl.carry_fb = 1'b1; end
      default:      ctrl.tap = TAP_NONE;
    endcase
  end

  assign drive_en = (ctrl.tap != TAP_NONE);

  // a driving opcode never loads from the bus it is driving
  p_no_load_while_driving_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> !(ctrl.ld_a || ctrl.ld_b || ctrl.ld_c));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |-> (!drive_en && !ctrl.carry_fb));
endmodule

// File: rtl/pe_cell.sv
module pe_cell
  import pe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pe_ctrl_t ctrl,
  input  logic     bus_in,
  output logic     bus_drv,
  output logic     c_out
);
  logic a_q, b_q, c_q;
  logic load_val;
  logic carry_w;
  logic sum_w;
  logic writes_any;

  assign load_val   = bus_in ^ ctrl.invert;
  assign carry_w    = fa_carry(a_q, b_q, c_q);
  assign sum_w      = fa_sum(a_q, b_q, c_q);
  assign writes_any = ctrl.ld_a | ctrl.ld_b | ctrl.ld_c | ctrl.carry_fb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      if (ctrl.ld_a) a_q <= load_val;
      if (ctrl.ld_b) b_q <= load_val;
      if (ctrl.ld_c) c_q <= bus_in;
      else if (ctrl.carry_fb) c_q <= carry_w;
    end
  end

  assign bus_drv = tap_value(ctrl.tap, a_q, b_q, c_q);
  assign c_out   = c_q;

  p_load_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ld_a |=> (a_q == ($past(bus_in) ^ $past(ctrl.invert))));
  p_load_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ld_b |=> (b_q == ($past(bus_in) ^ $past(ctrl.invert))));
  p_load_c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ld_c |=> (c_q == $past(bus_in)));
  p_carry_fb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.carry_fb && !ctrl.ld_c) |=> (c_q == $past(carry_w)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !writes_any |=> $stable({a_q, b_q, c_q}));
  p_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.tap == TAP_NONE) |-> !bus_drv);
  p_sum_tap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.tap == TAP_SUM) |-> (bus_drv == sum_w));
endmodule

// File: rtl/pe_any_or.sv
module pe_any_or #(
  parameter int N_COLS = 8
) (
  input  logic [N_COLS-1:0] c_vec,
  output logic              any_c
);
  logic [N_COLS:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N_COLS; i++) begin : g_or
    assign chain[i+1] = chain[i] | c_vec[i];
  end
  assign any_c = chain[N_COLS];
endmodule

// File: rtl/pe_row.sv
module pe_row
  import pe_pkg::*;
#(
  parameter int N_COLS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op,
  input  logic [N_COLS-1:0] bus_in,
  output logic [N_COLS-1:0] bus_out,
  output logic              drive_en,
  output logic              any_c
);
  pe_ctrl_t          ctrl;
  logic [N_COLS-1:0] c_vec;

  pe_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .ctrl     (ctrl),
    .drive_en (drive_en)
  );

  for (genvar i = 0; i < N_COLS; i++) begin : g_col
    pe_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl    (ctrl),
      .bus_in  (bus_in[i]),
      .bus_drv (bus_out[i]),
      .c_out   (c_vec[i])
    );
  end

  pe_any_or #(.N_COLS(N_COLS)) u_or (
    .c_vec (c_vec),
    .any_c (any_c)
  );

  p_any_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(c_vec) != 0) |-> any_c);
  p_any_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(c_vec) == 0) |-> !any_c);
  p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (bus_out == '0));
endmodule

// File: tb/pe_row_test.sv
module pe_row_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   op = 4'd15;
  logic [N-1:0] bus_in = '0;
  logic [N-1:0] bus_out;
  logic         drive_en;
  logic         any_c;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int ma[N], mb[N], mc[N];
  logic [N-1:0] last_bus;

  always #5 clk = ~clk;

  pe_row #(.N_COLS(N)) uut (
    .clk(clk), .rst_n(rst_n), .op(op), .bus_in(bus_in),
    .bus_out(bus_out), .drive_en(drive_en), .any_c(any_c)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int o);
    case (o)
      3, 6, 8, 10, 11: return "R2";
      2, 13:           return "R3,R11";
      0, 1, 4, 5, 7, 9: return "R4,R11";
      14:              return "R5";
      12:              return "R6";
      15:              return "R8";
      default:         return "R7";
    endcase
  endfunction

  function automatic int exp_drive(input int o, input int a, input int b, input int c);
    int s;
    s = a + b + c;
    case (o)
      0: return (b + c > 0) ? 1 : 0;
      1: return b * c;
      2: return (s >= 2) ? 1 : 0;
      4: return (a == 1) ? c : b;
      5: return (a == 1) ? b : c;
      7: return b;
      9: return (b != c) ? 1 : 0;
      13, 14: return s % 2;
      default: return 0;
    endcase
  endfunction

  // one broadcast cycle: drive, compare mid-cycle, clock, update model
  task automatic step(input int o, input logic [N-1:0] bv);
    int any_exp;
    bit drv;
    op = o[3:0];
    bus_in = bv;
    #3;
    drv = (o == 0 || o == 1 || o == 2 || o == 4 || o == 5 || o == 7 || o == 9 || o == 13 || o == 14);
    check("R7", int'(drive_en), drv ? 1 : 0, $sformatf("drive_en op=%0d", o));
    any_exp = 0;
    for (int i = 0; i < N; i++) begin
      check(tag_of(o), int'(bus_out[i]), exp_drive(o, ma[i], mb[i], mc[i]),
            $sformatf("bus_out col=%0d op=%0d", i, o));
      if (mc[i] != 0) any_exp = 1;
    end
    check("R9", int'(any_c), any_exp, "any_c");
    last_bus = bus_out;
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      int bit_v, cy;
      bit_v = int'(bv[i]);
      cy = (ma[i] + mb[i] + mc[i] >= 2) ? 1 : 0;
      case (o)
        3:  mc[i] = bit_v;
        6:  mb[i] = bit_v;
        8:  mb[i] = 1 - bit_v;
        10: ma[i] = bit_v;
        11: ma[i] = 1 - bit_v;
        12: begin ma[i] = bit_v; mc[i] = cy; end
        14: mc[i] = cy;
        default: ;
      endcase
    end
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired before completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] xs [N];
    logic [N-1:0] ys [N];
    logic [N-1:0] res [N];
    logic [N-1:0] xb, yb;
    for (int i = 0; i < N; i++) begin ma[i] = 0; mb[i] = 0; mc[i] = 0; end

    // R1: reset state, checked while in reset and after release
    op = 4'd7;
    #12;
    check("R1", int'(bus_out), 0, "bus_out in reset");
    check("R1", int'(any_c), 0, "any_c in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    step(7, '1);
    step(2, '1);
    step(0, '1);

    // R2/R11: directed loads, then read back through taps
    step(10, 8'hA5);
    step(8, 8'h0F);
    step(7, '0);
    step(4, '0);
    step(5, '0);
    step(3, 8'h3C);
    step(9, '0);
    step(11, 8'hFF);
    step(4, '0);
    step(6, 8'h55);
    step(1, '0);
    // R8: idle keeps everything
    step(15, 8'hFF);
    step(15, 8'h00);
    step(13, '0);
    step(2, '0);
    // R6: load A with carry feedback from old values
    step(12, 8'hF0);
    step(7, '0); step(13, '0); step(2, '0);
    // R9: C cleared everywhere, then a single column set
    step(3, '0);
    step(3, 8'h80);
    step(3, '0);

    // R10: serial add, LSB first
    for (int i = 0; i < N; i++) begin
      xs[i] = 8'($urandom);
      ys[i] = 8'($urandom);
      res[i] = '0;
    end
    xs[0] = 8'hFF; ys[0] = 8'h01;
    step(3, '0);
    for (int k = 0; k < N; k++) begin
      for (int i = 0; i < N; i++) begin xb[i] = xs[i][k]; yb[i] = ys[i][k]; end
      step(10, xb);
      step(6, yb);
      step(14, '0);
      for (int i = 0; i < N; i++) res[i][k] = last_bus[i];
    end
    for (int i = 0; i < N; i++)
      check("R10", int'(res[i]), int'(8'(xs[i] + ys[i])), $sformatf("serial add col=%0d", i));

    // R10: serial subtract with C set and inverted subtrahend
    xs[1] = 8'h00; ys[1] = 8'h01;
    step(3, '1);
    for (int k = 0; k < N; k++) begin
      for (int i = 0; i < N; i++) begin xb[i] = xs[i][k]; yb[i] = ys[i][k]; end
      step(11, yb);
      step(6, xb);
      step(14, '0);
      for (int i = 0; i < N; i++) res[i][k] = last_bus[i];
    end
    for (int i = 0; i < N; i++)
      check("R10", int'(res[i]), int'(8'(xs[i] - ys[i])), $sformatf("serial sub col=%0d", i));

    // random opcodes and bus values against the model (R2..R9, R11)
    for (int t = 0; t < 4000; t++) begin
      step(int'($urandom_range(0, 15)), N'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule